// File: doc/BRIEF.md
# ADC Command Frame Decoder

This block sits behind the serial port of a multi-channel converter. Each 16-bit command word arrives in parallel from an SPI shifter. With it come a one-cycle frame-done strobe and a flag that says whether all 16 bits were clocked in before chip select went high. The block decodes the word and keeps the converter's control state: the active mode, the input range, the power-down request, the response format and the GPIO output levels. On each qualifying frame it sends one-cycle strobes to the channel sequencer.

Only the auto-scan mode code is acted on. Any other mode code leaves the state unchanged. A separate code arms a two-frame handshake: the next complete frame is passed on whole as the 16-bit channel-enable mask, and it touches no other setting. The block also builds the 16-bit response word. The top nibble is the current channel address or the GPIO input levels, chosen by the stored format bit. The low 12 bits are the conversion result.

Top module: `adc_cmd_decoder`

## Requirements
- R1: While reset is held, and after it is released until the first frame, mode_code, range_x2, pdn_req, fmt_gpio, gpio_out and mask_data are all 0, and no strobe is high.
- R2: A complete frame with bits 15:12 = 4'b0010 sets mode_code to 4'b0010. seq_enter pulses only if mode_code was not already 4'b0010.
- R3: In an auto-scan frame with bit 11 = 1, range_x2 takes bit 6, pdn_req takes bit 5 and fmt_gpio takes bit 4. With bit 11 = 0, all three keep their previous values.
- R4: seq_cnt_rst pulses for an auto-scan frame that has bit 11 = 1 and bit 10 = 1. It stays low when either bit is 0.
- R5: In an auto-scan frame with bit 11 = 1, gpio_out[i] takes frame bit i only where gpio_dir[i] = 1 (pin is an output). Bits whose pin is an input keep their value.
- R6: A complete frame with bits 15:12 = 4'b1000 arms mask programming and changes nothing else. The next complete frame, whatever its contents, pulses mask_wr and is presented whole on mask_data.
- R7: The mask frame does not change mode_code, range_x2, pdn_req, fmt_gpio or gpio_out, and it raises neither seq_enter nor seq_cnt_rst.
- R8: A complete frame with any other command code changes no output state and raises no strobe.
- R9: A frame delivered with frame_full = 0 is discarded entirely. It leaves the state unchanged, and a pending mask handshake stays armed.
- R10: resp_word is {chan_addr, conv_result} when fmt_gpio = 0 and {gpio_in, conv_result} when fmt_gpio = 1.
- R11: Strobes are registered. Each is high for exactly the one cycle after the clock edge that samples frame_done with frame_full = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_word | input | 16 | Received command word |
| frame_done | input | 1 | One-cycle strobe at end of frame |
| frame_full | input | 1 | All 16 bits received before chip select rose |
| gpio_dir | input | 4 | Per-pin direction, 1 = output |
| gpio_in | input | 4 | GPIO pin levels |
| chan_addr | input | 4 | Address of channel being converted |
| conv_result | input | 12 | Conversion result |
| mode_code | output | 4 | Current mode code |
| range_x2 | output | 1 | 1 selects the doubled input range |
| pdn_req | output | 1 | Power-down request at end of frame |
| fmt_gpio | output | 1 | Response top nibble carries GPIO inputs |
| gpio_out | output | 4 | GPIO output levels |
| seq_enter | output | 1 | Strobe: auto-scan mode entered |
| seq_cnt_rst | output | 1 | Strobe: restart at lowest enabled channel |
| mask_wr | output | 1 | Strobe: channel mask written |
| mask_data | output | 16 | Channel-enable mask |
| resp_word | output | 16 | Response word for the shifter |

## Verification
The assertions check on every cycle that strobes are one cycle wide and follow only a complete frame. They also check that input-configured GPIO bits never move, that settings stay put unless an update-enabled auto-scan frame arrives, and that the mask handshake arms and disarms correctly. Only the bench scenarios can show the actual values: which bits land in which setting, the enable gating of bit 10, the mask contents, the two response formats, and the fact that a truncated frame does not disarm the handshake.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;
  localparam int FRAME_W   = 16;
  localparam int CODE_W    = 4;
  localparam int CODE_LO   = 12;
  localparam int BIT_UPD   = 11;
  localparam int BIT_CRST  = 10;
  localparam int BIT_RANGE = 6;
  localparam int BIT_PDN   = 5;
  localparam int BIT_FMT   = 4;

  localparam logic [CODE_W-1:0] CODE_AUTO  = 4'b0010;
  localparam logic [CODE_W-1:0] CODE_MASK  = 4'b1000;
  localparam logic [CODE_W-1:0] MODE_RESET = 4'b0000;

  typedef enum logic [2:0] {
    K_NONE,
    K_AUTO,
    K_MASK_ARM,
    K_MASK_DATA,
    K_OTHER
  } cmd_kind_t;
endpackage

// File: rtl/adc_cmd_classify.sv
module adc_cmd_classify
  import adc_cmd_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              done_i,
  input  logic              full_i,
  input  logic              armed_i,
  output cmd_kind_t         kind_o
);
  logic valid;

  always_comb begin
    valid  = done_i & full_i;
    kind_o = K_NONE;
    if (valid) begin
      if (armed_i)                kind_o = K_MASK_DATA;
      else if (code_i == CODE_AUTO) kind_o = K_AUTO;
      else if (code_i == CODE_MASK) kind_o = K_MASK_ARM;
      else                        kind_o = K_OTHER;
    end
  end
endmodule

// File: rtl/adc_mask_handshake.sv
module adc_mask_handshake
  import adc_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cmd_kind_t kind_i,
  output logic      armed_o
);
  logic arm_q, arm_d;

  always_comb begin
    arm_d = arm_q;
    if (kind_i == K_MASK_ARM)       arm_d = 1'b1;
    else if (kind_i == K_MASK_DATA) arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_d;
  end

  assign armed_o = arm_q;

  assert_arm_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == K_MASK_ARM) |=> armed_o);
  assert_arm_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && kind_i == K_MASK_DATA) |=> !armed_o);
  assert_short_keeps_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == K_NONE) |=> $stable(armed_o));
endmodule

// File: rtl/adc_cmd_settings.sv
module adc_cmd_settings
  import adc_cmd_pkg::*;
#(
  parameter int GPIO_N = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cmd_kind_t          kind_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic [GPIO_N-1:0]  gpio_dir_i,
  output logic [CODE_W-1:0]  mode_o,
  output logic               range_o,
  output logic               pdn_o,
  output logic               fmt_o,
  output logic [GPIO_N-1:0]  gpio_out_o,
  output logic               enter_o,
  output logic               cnt_rst_o,
  output logic               mask_wr_o,
  output logic [FRAME_W-1:0] mask_o
);
  logic [CODE_W-1:0]  mode_q, mode_d;
  logic               range_q, range_d, pdn_q, pdn_d, fmt_q, fmt_d;
  logic [GPIO_N-1:0]  gpio_q, gpio_d;
  logic               enter_q, enter_d, crst_q, crst_d, mwr_q, mwr_d;
  logic [FRAME_W-1:0] mask_q, mask_d;
  logic               upd_en;

  always_comb begin
    mode_d  = mode_q;
    range_d = range_q;
    pdn_d   = pdn_q;
    fmt_d   = fmt_q;
    gpio_d  = gpio_q;
    mask_d  = mask_q;
    enter_d = 1'b0;
    crst_d  = 1'b0;
    mwr_d   = 1'b0;
    upd_en  = (kind_i == K_AUTO) && word_i[BIT_UPD];
    unique case (kind_i)
      K_AUTO: begin
        mode_d  = CODE_AUTO;
        enter_d = (mode_q != CODE_AUTO);
        if (upd_en) begin
          range_d = word_i[BIT_RANGE];
          pdn_d   = word_i[BIT_PDN];
          fmt_d   = word_i[BIT_FMT];
          crst_d  = word_i[BIT_CRST];
          for (int i = 0; i < GPIO_N; i++) begin
            if (gpio_dir_i[i]) gpio_d[i] = word_i[i];
          end
        end
      end
      K_MASK_DATA: begin
        mwr_d  = 1'b1;
        mask_d = word_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RESET;
      range_q <= 1'b0;
      pdn_q   <= 1'b0;
      fmt_q   <= 1'b0;
      gpio_q  <= '0;
      mask_q  <= '0;
      enter_q <= 1'b0;
      crst_q  <= 1'b0;
      mwr_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      range_q <= range_d;
      pdn_q   <= pdn_d;
      fmt_q   <= fmt_d;
      gpio_q  <= gpio_d;
      mask_q  <= mask_d;
      enter_q <= enter_d;
      crst_q  <= crst_d;
      mwr_q   <= mwr_d;
    end
  end

  assign mode_o     = mode_q;
  assign range_o    = range_q;
  assign pdn_o      = pdn_q;
  assign fmt_o      = fmt_q;
  assign gpio_out_o = gpio_q;
  assign mask_o     = mask_q;
  assign enter_o    = enter_q;
  assign cnt_rst_o  = crst_q;
  assign mask_wr_o  = mwr_q;

  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_RESET) || (mode_o == CODE_AUTO));
  assert_enter_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |=> !enter_o);
  assert_hold_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(kind_i == K_AUTO && word_i[BIT_UPD]) |=> $stable({range_o, pdn_o, fmt_o}));
  assert_crst_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(kind_i == K_AUTO && word_i[BIT_UPD]) |=> !cnt_rst_o);
  assert_mask_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_o |=> !mask_wr_o);

  for (genvar g = 0; g < GPIO_N; g++) begin : g_pin_chk
    assert_input_pin_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !gpio_dir_i[g] |=> $stable(gpio_out_o[g]));
  end
endmodule

// File: rtl/adc_resp_mux.sv
module adc_resp_mux #(
  parameter int TAG_W = 4,
  parameter int RES_W = 12
) (
  input  logic                   fmt_i,
  input  logic [TAG_W-1:0]       addr_i,
  input  logic [TAG_W-1:0]       gpio_i,
  input  logic [RES_W-1:0]       result_i,
  output logic [TAG_W+RES_W-1:0] resp_o
);
  for (genvar b = 0; b < TAG_W; b++) begin : g_tag
    assign resp_o[RES_W+b] = fmt_i ? gpio_i[b] : addr_i[b];
  end
  assign resp_o[RES_W-1:0] = result_i;
endmodule

// File: rtl/adc_cmd_decoder.sv
module adc_cmd_decoder
  import adc_cmd_pkg::*;
#(
  parameter int GPIO_N = 4,
  parameter int RES_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [FRAME_W-1:0]        frame_word,
  input  logic                      frame_done,
  input  logic                      frame_full,
  input  logic [GPIO_N-1:0]         gpio_dir,
  input  logic [GPIO_N-1:0]         gpio_in,
  input  logic [ADDR_W-1:0]         chan_addr,
  input  logic [RES_W-1:0]          conv_result,
  output logic [CODE_W-1:0]         mode_code,
  output logic                      range_x2,
  output logic                      pdn_req,
  output logic                      fmt_gpio,
  output logic [GPIO_N-1:0]         gpio_out,
  output logic                      seq_enter,
  output logic                      seq_cnt_rst,
  output logic                      mask_wr,
  output logic [FRAME_W-1:0]        mask_data,
  output logic [ADDR_W+RES_W-1:0]   resp_word
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       armed;
  cmd_kind_t  kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  adc_cmd_classify u_classify (
    .code_i  (frame_word[FRAME_W-1:CODE_LO]),
    .done_i  (frame_done),
    .full_i  (frame_full),
    .armed_i (armed),
    .kind_o  (kind)
  );

  adc_mask_handshake u_mask_hs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .kind_i  (kind),
    .armed_o (armed)
  );

  adc_cmd_settings #(.GPIO_N(GPIO_N)) u_settings (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .kind_i     (kind),
    .word_i     (frame_word),
    .gpio_dir_i (gpio_dir),
    .mode_o     (mode_code),
    .range_o    (range_x2),
    .pdn_o      (pdn_req),
    .fmt_o      (fmt_gpio),
    .gpio_out_o (gpio_out),
    .enter_o    (seq_enter),
    .cnt_rst_o  (seq_cnt_rst),
    .mask_wr_o  (mask_wr),
    .mask_o     (mask_data)
  );

  adc_resp_mux #(.TAG_W(ADDR_W), .RES_W(RES_W)) u_resp (
    .fmt_i    (fmt_gpio),
    .addr_i   (chan_addr),
    .gpio_i   (gpio_in),
    .result_i (conv_result),
    .resp_o   (resp_word)
  );

  assert_strobe_after_frame_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq_enter || seq_cnt_rst || mask_wr) |-> $past(frame_done && frame_full));
  assert_mask_frame_inert_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mask_wr |-> (!seq_enter && !seq_cnt_rst &&
                 $stable({mode_code, range_x2, pdn_req, fmt_gpio, gpio_out})));
  assert_short_frame_inert_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_done && !frame_full) |=> (!seq_enter && !seq_cnt_rst && !mask_wr &&
      $stable({mode_code, range_x2, pdn_req, fmt_gpio, gpio_out, mask_data})));
endmodule

// File: tb/adc_cmd_decoder_bench.sv
module adc_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] frame_word;
  logic        frame_done, frame_full;
  logic [3:0]  gpio_dir, gpio_in, chan_addr;
  logic [11:0] conv_result;
  logic [3:0]  mode_code;
  logic        range_x2, pdn_req, fmt_gpio;
  logic [3:0]  gpio_out;
  logic        seq_enter, seq_cnt_rst, mask_wr;
  logic [15:0] mask_data, resp_word;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_cmd_decoder u_adc_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .frame_word(frame_word), .frame_done(frame_done),
    .frame_full(frame_full), .gpio_dir(gpio_dir), .gpio_in(gpio_in),
    .chan_addr(chan_addr), .conv_result(conv_result), .mode_code(mode_code),
    .range_x2(range_x2), .pdn_req(pdn_req), .fmt_gpio(fmt_gpio),
    .gpio_out(gpio_out), .seq_enter(seq_enter), .seq_cnt_rst(seq_cnt_rst),
    .mask_wr(mask_wr), .mask_data(mask_data), .resp_word(resp_word)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one frame on a falling edge; return after the edge that registers it.
  task automatic send(input logic [15:0] w, input logic full);
    @(negedge clk);
    frame_word = w;
    frame_full = full;
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    frame_full = 1'b0;
  endtask

  task automatic chk_state(input string req, input logic [3:0] m, input logic r,
                           input logic p, input logic f, input logic [3:0] g);
    chk(req, "mode_code", 32'(mode_code), 32'(m));
    chk(req, "range_x2",  32'(range_x2),  32'(r));
    chk(req, "pdn_req",   32'(pdn_req),   32'(p));
    chk(req, "fmt_gpio",  32'(fmt_gpio),  32'(f));
    chk(req, "gpio_out",  32'(gpio_out),  32'(g));
  endtask

  task automatic chk_strobes(input string req, input logic e, input logic c, input logic w);
    chk(req, "seq_enter",   32'(seq_enter),   32'(e));
    chk(req, "seq_cnt_rst", 32'(seq_cnt_rst), 32'(c));
    chk(req, "mask_wr",     32'(mask_wr),     32'(w));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_state("R1", 4'h0, 0, 0, 0, 4'h0);
    chk_strobes("R1", 0, 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_state("R1", 4'h0, 0, 0, 0, 4'h0);
    chk("R1", "mask_data", 32'(mask_data), 32'h0);
  endtask

  task automatic t_auto_entry;
    send(16'h287A, 1'b1);
    chk_strobes("R2", 1, 0, 0);
    chk_state("R3", 4'h2, 1, 1, 1, 4'b1000);  // R5: only pins 3,2 are outputs
    @(negedge clk);
    chk_strobes("R11", 0, 0, 0);
  endtask

  task automatic t_hold_fields;
    send(16'h2400, 1'b1);  // update disabled, bit 10 set
    chk_strobes("R4", 0, 0, 0);
    chk_state("R3", 4'h2, 1, 1, 1, 4'b1000);
  endtask

  task automatic t_counter_reset;
    send(16'h2C05, 1'b1);
    chk_strobes("R4", 0, 1, 0);
    chk_state("R5", 4'h2, 0, 0, 0, 4'b0100);
    @(negedge clk);
    chk("R11", "seq_cnt_rst", 32'(seq_cnt_rst), 32'h0);
  endtask

  task automatic t_response;
    chan_addr = 4'h9; gpio_in = 4'h6; conv_result = 12'h5A3;
    #1 chk("R10", "resp addr fmt", 32'(resp_word), 32'h95A3);
    send(16'h2850, 1'b1);
    chk_state("R3", 4'h2, 1, 0, 1, 4'b0000);
    chk("R10", "resp gpio fmt", 32'(resp_word), 32'h65A3);
  endtask

  task automatic t_mask;
    send(16'h8ABC, 1'b1);
    chk_strobes("R6", 0, 0, 0);
    chk_state("R6", 4'h2, 1, 0, 1, 4'b0000);
    send(16'h2C2F, 1'b1);
    chk_strobes("R7", 0, 0, 1);
    chk("R6", "mask_data", 32'(mask_data), 32'h2C2F);
    chk_state("R7", 4'h2, 1, 0, 1, 4'b0000);
    @(negedge clk);
    chk("R11", "mask_wr", 32'(mask_wr), 32'h0);
  endtask

  task automatic t_short_frames;
    send(16'h8000, 1'b1);
    send(16'h1234, 1'b0);
    chk_strobes("R9", 0, 0, 0);
    chk("R9", "mask_data", 32'(mask_data), 32'h2C2F);
    send(16'h00F0, 1'b1);
    chk_strobes("R9", 0, 0, 1);
    chk("R9", "mask after short", 32'(mask_data), 32'h00F0);
    send(16'h2C2F, 1'b0);
    chk_strobes("R9", 0, 0, 0);
    chk_state("R9", 4'h2, 1, 0, 1, 4'b0000);
  endtask

  task automatic t_unsupported;
    send(16'h1FFF, 1'b1);
    chk_strobes("R8", 0, 0, 0);
    chk_state("R8", 4'h2, 1, 0, 1, 4'b0000);
    send(16'hAFFF, 1'b1);
    chk_strobes("R8", 0, 0, 0);
    chk("R8", "mask_data", 32'(mask_data), 32'h00F0);
  endtask

  task automatic t_reentry;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send(16'h0FFF, 1'b1);
    chk_strobes("R8", 0, 0, 0);
    send(16'h2000, 1'b1);
    chk_strobes("R2", 1, 0, 0);
    chk_state("R3", 4'h2, 0, 0, 0, 4'b0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    frame_word = '0; frame_done = 1'b0; frame_full = 1'b0;
    gpio_dir = 4'b1100; gpio_in = '0; chan_addr = '0; conv_result = '0;
    t_reset();
    t_auto_entry();
    t_hold_fields();
    t_counter_reset();
    t_response();
    t_mask();
    t_short_frames();
    t_unsupported();
    t_reentry();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule